// File: doc/BRIEF.md
# Single-to-Half Precision Float Packer

This block turns a 32-bit IEEE single-precision bit pattern into a 16-bit half-precision pattern. It places the result in one 16-bit lane of a 32-bit output word. A lane-select input chooses the lower or the upper lane, and the other lane is zero. This lets a caller OR two conversions together to build a packed pair of halves.

The conversion handles the sign, infinities, quiet-NaN canonicalisation, saturation of large finite values to infinity, and gradual underflow into half denormals. Every finite case uses one rounding rule: add half of an output ULP, then truncate. Exact ties therefore move away from zero, not to even. A parameter adds a single output register with a synchronous active-low reset. Without it, the path is purely combinational.

Top module: `f2h_convert`

## Requirements
- R1: The sign of the output half is always the input's bit 31. This includes zeros, infinities and NaNs.
- R2: An input with exponent field 255 and a zero mantissa gives half magnitude 0x7C00.
- R3: An input with exponent field 255 and a nonzero mantissa gives half magnitude 0x7E00, whatever the payload.
- R4: For exponent field E in 113..142, the half magnitude is `((E-112)<<10 | M[22:13]) + M[12]`, where M is the 23-bit mantissa. Mantissa bits 11:0 have no effect, and an exact tie rounds away from zero.
- R5: Finite inputs with E of 143 or more saturate to 0x7C00. So do R4 results that round up to 0x7C00 or beyond. 0x477FE000 gives 0x7BFF and 0x477FF000 gives 0x7C00.
- R6: For E in 1..112, let S = {1, M} (24 bits) and sh = 126-E. The half magnitude is `(S >> sh) + S[sh-1]`, and it is 0 when sh exceeds 24. The result is never above 0x0400.
- R7: An input with E = 0 (zero or single-precision denormal) gives half magnitude 0, keeping the sign.
- R8: With `place_high` = 0, the half is at bits 15:0 with its sign in bit 15, and bits 31:16 are zero. With `place_high` = 1, the half is at bits 31:16 with its sign in bit 31, and bits 15:0 are zero.
- R9: With `REG_OUT` = 0, `word_out` follows the inputs in the same cycle. With `REG_OUT` = 1, it shows the result one clock after the inputs were sampled, and a clock edge with `rst_n` low clears it to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| sp_bits | input | 32 | Single-precision input bit pattern |
| place_high | input | 1 | Lane select: 0 puts the half in bits 15:0, 1 in bits 31:16 |
| word_out | output | 32 | Packed word holding the half in the selected lane |

## Verification
The bench builds the block twice, with `REG_OUT` = 1 and `REG_OUT` = 0, and drives both instances from the same stimulus. The combinational instance exposes every conversion in the cycle it is applied. The registered instance shows the one-cycle delay and the clearing by a synchronous reset held in the middle of a run. Directed vectors hit ties of both signs, the largest finite half, the saturation edge, the normal/denormal boundary, the last input that rounds to the smallest denormal, and NaN payloads. A full exponent sweep and random patterns cover the remaining classes in both lanes.

// File: rtl/f2h_pkg.sv
// Package: f2h_pkg
// Shared format constants, field layout and input classes for the
// single-to-half packer. All thresholds derive from the format widths.
package f2h_pkg;

    localparam int SP_EXP_W = 8;
    localparam int SP_MAN_W = 23;
    localparam int SP_W     = 1 + SP_EXP_W + SP_MAN_W;

    localparam int HP_EXP_W = 5;
    localparam int HP_MAN_W = 10;
    localparam int HP_W     = 1 + HP_EXP_W + HP_MAN_W;
    localparam int HP_MAG_W = HP_W - 1;

    localparam int SP_BIAS    = (1 << (SP_EXP_W - 1)) - 1;
    localparam int HP_BIAS    = (1 << (HP_EXP_W - 1)) - 1;
    localparam int REBIAS     = SP_BIAS - HP_BIAS;
    localparam int HP_EXP_TOP = (1 << HP_EXP_W) - 1;
    localparam int OVF_EXP    = REBIAS + HP_EXP_TOP;
    localparam int DROP_W     = SP_MAN_W - HP_MAN_W;
    // shift that maps a single significand onto half-denormal units
    localparam int SUB_SH_BASE = SP_BIAS + SP_MAN_W - HP_BIAS - HP_MAN_W + 1;

    localparam logic [HP_MAG_W-1:0] HP_INF_MAG  = HP_MAG_W'(HP_EXP_TOP << HP_MAN_W);
    localparam logic [HP_MAG_W-1:0] HP_QNAN_MAG = HP_INF_MAG | HP_MAG_W'(1 << (HP_MAN_W - 1));
    localparam logic [HP_MAG_W-1:0] HP_MIN_NORM = HP_MAG_W'(1 << HP_MAN_W);

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORM,
        CLS_OVF,
        CLS_INF,
        CLS_NAN
    } f2h_cls_e;

    typedef struct packed {
        logic                sign;
        logic [SP_EXP_W-1:0] exp;
        logic [SP_MAN_W-1:0] man;
    } sp_fields_t;

endpackage

// File: rtl/f2h_classify.sv
// Module: f2h_classify
// Splits a single-precision pattern into sign, exponent and mantissa and
// sorts the magnitude into one conversion class.
// Assumes: combinational, exponent all-ones checked before saturation.
module f2h_classify
    import f2h_pkg::*;
(
    input  logic [SP_W-1:0] sp_bits,
    output sp_fields_t      fields,
    output f2h_cls_e        cls
);

    localparam logic [SP_EXP_W-1:0] EXP_ONES = '1;
    localparam logic [SP_EXP_W-1:0] EXP_REB  = SP_EXP_W'(REBIAS);
    localparam logic [SP_EXP_W-1:0] EXP_OVF  = SP_EXP_W'(OVF_EXP);

    // Purpose: unpack the fields and pick the class by exponent range.
    always_comb begin
        fields = sp_fields_t'(sp_bits);
        if (fields.exp == '0) begin
            cls = CLS_ZERO;
        end else if (fields.exp == EXP_ONES) begin
            cls = (fields.man == '0) ? CLS_INF : CLS_NAN;
        end else if (fields.exp >= EXP_OVF) begin
            cls = CLS_OVF;
        end else if (fields.exp > EXP_REB) begin
            cls = CLS_NORM;
        end else begin
            cls = CLS_SUB;
        end
    end

endmodule

// File: rtl/f2h_norm_round.sv
// Module: f2h_norm_round
// Rebiases a normal-range exponent and rounds the kept mantissa by adding
// the first dropped bit (half an output ULP, ties away from zero).
// Assumes: exponent already in the normal half range; the caller saturates.
module f2h_norm_round
    import f2h_pkg::*;
(
    input  logic [SP_EXP_W-1:0] exp_in,
    input  logic [HP_MAN_W:0]   man_top,
    output logic [HP_MAG_W-1:0] mag,
    output logic                to_inf
);

    logic [HP_EXP_W-1:0] half_exp;
    logic [HP_MAG_W-1:0] sum;

    // Purpose: rebias, add the round bit and flag a result reaching infinity.
    always_comb begin
        half_exp = HP_EXP_W'(exp_in - SP_EXP_W'(REBIAS));
        sum      = {half_exp, man_top[HP_MAN_W:1]} + HP_MAG_W'(man_top[0]);
        to_inf   = (sum >= HP_INF_MAG);
        mag      = sum;
    end

endmodule

// File: rtl/f2h_sub_shift.sv
// Module: f2h_sub_shift
// Shifts the full single significand into half-denormal units and rounds
// by adding the highest bit shifted out. A shift beyond the significand
// leaves zero.
// Assumes: exponent lies below the smallest normal half (1..REBIAS).
module f2h_sub_shift
    import f2h_pkg::*;
(
    input  logic [SP_EXP_W-1:0] exp_in,
    input  logic [SP_MAN_W-1:0] man_in,
    output logic [HP_MAG_W-1:0] mag
);

    localparam int EXT_W = SP_MAN_W + 2;

    logic [SP_EXP_W-1:0] sh;
    logic [EXT_W-1:0]    ext;
    logic [EXT_W-1:0]    shifted;

    // Purpose: one guard bit below the significand carries the round bit out.
    always_comb begin
        sh      = SP_EXP_W'(SUB_SH_BASE) - exp_in;
        ext     = {1'b1, man_in, 1'b0};
        shifted = ext >> sh;
        mag     = HP_MAG_W'(shifted >> 1) + HP_MAG_W'(shifted[0]);
    end

endmodule

// File: rtl/f2h_place.sv
// Module: f2h_place
// Puts the signed half into the selected 16-bit lane of the output word,
// optionally through one register with synchronous active-low reset.
// Assumes: the output word holds exactly two half lanes.
module f2h_place
    import f2h_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
)
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sign,
    input  logic [HP_MAG_W-1:0] mag,
    input  logic                place_high,
    output logic [SP_W-1:0]     word_out
);

    logic [SP_W-1:0] word_d;

    // Purpose: steer the signed half into the low or high lane.
    always_comb begin
        word_d = '0;
        if (place_high) begin
            word_d[SP_W-1 -: HP_W] = {sign, mag};
        end else begin
            word_d[HP_W-1:0] = {sign, mag};
        end
    end

    generate
        if (REG_OUT) begin : g_reg
            logic [SP_W-1:0] word_q;

            // Purpose: hold the packed word for one clock, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else begin
                    word_q <= word_d;
                end
            end

            assign word_out = word_q;

            assert_high_lane_R8: assert property (@(posedge clk) disable iff (!rst_n)
                $past(place_high) |-> (word_out[HP_W-1:0] == '0));
            assert_low_lane_R8: assert property (@(posedge clk) disable iff (!rst_n)
                !$past(place_high) |-> (word_out[SP_W-1 -: HP_W] == '0));
        end else begin : g_comb
            assign word_out = word_d;

            assert_high_lane_R8: assert property (@(posedge clk) disable iff (!rst_n)
                place_high |-> (word_out[HP_W-1:0] == '0));
            assert_low_lane_R8: assert property (@(posedge clk) disable iff (!rst_n)
                !place_high |-> (word_out[SP_W-1 -: HP_W] == '0));
        end
    endgenerate

endmodule

// File: rtl/f2h_convert.sv
// Module: f2h_convert (top)
// Converts a single-precision pattern to a half and packs it into one lane
// of a 32-bit word. Classifies the input, runs the normal and denormal
// rounding paths side by side, picks one magnitude and hands it to the lane
// placer.
// Assumes: REG_OUT selects one output register; otherwise combinational.
module f2h_convert
    import f2h_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
)
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SP_W-1:0] sp_bits,
    input  logic            place_high,
    output logic [SP_W-1:0] word_out
);

    sp_fields_t          fields;
    f2h_cls_e            cls;
    logic [HP_MAG_W-1:0] norm_mag;
    logic                norm_to_inf;
    logic [HP_MAG_W-1:0] sub_mag;
    logic [HP_MAG_W-1:0] half_mag;

    f2h_classify u_classify (
        .sp_bits (sp_bits),
        .fields  (fields),
        .cls     (cls)
    );

    f2h_norm_round u_norm_round (
        .exp_in  (fields.exp),
        .man_top (fields.man[SP_MAN_W-1 -: HP_MAN_W+1]),
        .mag     (norm_mag),
        .to_inf  (norm_to_inf)
    );

    f2h_sub_shift u_sub_shift (
        .exp_in (fields.exp),
        .man_in (fields.man),
        .mag    (sub_mag)
    );

    // Purpose: choose the half magnitude for the input's class.
    always_comb begin
        unique case (cls)
            CLS_ZERO: half_mag = '0;
            CLS_SUB:  half_mag = sub_mag;
            CLS_NORM: half_mag = norm_to_inf ? HP_INF_MAG : norm_mag;
            CLS_OVF:  half_mag = HP_INF_MAG;
            CLS_INF:  half_mag = HP_INF_MAG;
            CLS_NAN:  half_mag = HP_QNAN_MAG;
            default:  half_mag = '0;
        endcase
    end

    f2h_place #(.REG_OUT(REG_OUT)) u_place (
        .clk        (clk),
        .rst_n      (rst_n),
        .sign       (fields.sign),
        .mag        (half_mag),
        .place_high (place_high),
        .word_out   (word_out)
    );

    // Checks on the selected magnitude against the raw input port fields.
    logic [SP_EXP_W-1:0] chk_exp;
    logic                chk_man_nz;
    assign chk_exp    = sp_bits[SP_W-2 -: SP_EXP_W];
    assign chk_man_nz = |sp_bits[SP_MAN_W-1:0];

    assert_inf_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((chk_exp == '1) && !chk_man_nz) |-> (half_mag == HP_INF_MAG));
    assert_qnan_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((chk_exp == '1) && chk_man_nz) |-> (half_mag == HP_QNAN_MAG));
    assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((chk_exp >= SP_EXP_W'(OVF_EXP)) && (chk_exp != '1)) |-> (half_mag == HP_INF_MAG));
    assert_sub_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((chk_exp != '0) && (chk_exp <= SP_EXP_W'(REBIAS))) |-> (half_mag <= HP_MIN_NORM));
    assert_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_exp == '0) |-> (half_mag == '0));

endmodule

// File: tb/f2h_convert_bench.sv
// Bench for f2h_convert: a registered and a combinational instance share
// the stimulus; a behavioural integer model predicts every output word.
module f2h_convert_bench;

    localparam int CLK_PERIOD      = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] sp_bits = '0;
    logic        place_high = 1'b0;
    logic [31:0] word_reg;
    logic [31:0] word_comb;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] pend_word[$];
    string       pend_req[$];

    f2h_convert #(.REG_OUT(1'b1)) u_f2h_convert (
        .clk (clk), .rst_n (rst_n), .sp_bits (sp_bits),
        .place_high (place_high), .word_out (word_reg)
    );

    f2h_convert #(.REG_OUT(1'b0)) u_f2h_convert_comb (
        .clk (clk), .rst_n (rst_n), .sp_bits (sp_bits),
        .place_high (place_high), .word_out (word_comb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural model: exact value scaling and remainder-based rounding.
    function automatic logic [15:0] model_half(input logic [31:0] f);
        int     e;
        int     u;
        int     ulp_e;
        int     k;
        int     h;
        longint s;
        longint q;
        longint rem;
        e = int'(f[30:23]);
        if (e == 255) begin
            h = (f[22:0] == 0) ? 'h7C00 : 'h7E00;
        end else if (e == 0) begin
            h = 0;
        end else begin
            s = longint'(f[22:0]) + (64'sd1 <<< 23);
            u = e - 127;
            if (u > 15) begin
                h = 'h7C00;
            end else begin
                ulp_e = (u >= -14) ? (u - 10) : -24;
                k = ulp_e - (e - 150);
                if (k > 40) begin
                    q = 0;
                end else begin
                    q = s >>> k;
                    rem = s - (q <<< k);
                    if (2 * rem >= (64'sd1 <<< k)) q = q + 1;
                end
                if (u >= -14) h = ((u + 15) <<< 10) + int'(q) - 1024;
                else          h = int'(q);
                if (h >= 'h7C00) h = 'h7C00;
            end
        end
        return {f[31], h[14:0]};
    endfunction

    function automatic string tag_for(input logic [31:0] f);
        int e;
        e = int'(f[30:23]);
        if (e == 255) return (f[22:0] == 0) ? "R2" : "R3";
        if (e == 0)   return "R7";
        if (e >= 143) return "R5";
        if (e > 112)  return (f[30:0] >= 31'h477FF000) ? "R5" : "R4";
        return "R6";
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp_v);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Drive one vector at a falling edge; check the delayed word first.
    task automatic apply(input logic [31:0] f, input bit hi);
        logic [15:0] h;
        logic [31:0] exp_w;
        string       req;
        @(negedge clk);
        if (pend_word.size() > 0) begin
            check({pend_req.pop_front(), " R9"}, "registered word", word_reg, pend_word.pop_front());
        end
        sp_bits    = f;
        place_high = hi;
        #1;
        h     = model_half(f);
        exp_w = hi ? {h, 16'h0000} : {16'h0000, h};
        req   = tag_for(f);
        check(req, "combinational word", word_comb, exp_w);
        check("R1", "sign bit", {31'd0, hi ? word_comb[31] : word_comb[15]}, {31'd0, f[31]});
        check("R8", "unused lane", {16'd0, hi ? word_comb[15:0] : word_comb[31:16]}, 32'd0);
        pend_word.push_back(exp_w);
        pend_req.push_back(req);
    endtask

    task automatic drain();
        @(negedge clk);
        while (pend_word.size() > 0) begin
            check({pend_req.pop_front(), " R9"}, "registered word", word_reg, pend_word.pop_front());
        end
    endtask

    logic [31:0] directed [26] = '{
        32'h0000_0000, 32'h8000_0000, 32'h3F80_0000, 32'hC000_0000,
        32'h3F80_1000, 32'hBF80_1000, 32'h3F80_0FFF, 32'h3F80_3000,
        32'h477F_E000, 32'h477F_F000, 32'h4780_0000, 32'h7F7F_FFFF,
        32'hFF7F_FFFF, 32'h7F80_0000, 32'hFF80_0000, 32'h7FC0_0000,
        32'h7F80_0001, 32'hFFFF_FFFF, 32'h3880_0000, 32'h387F_F000,
        32'h3380_0000, 32'h3300_0000, 32'h32FF_FFFF, 32'h0000_0001,
        32'h8040_0000, 32'hB87F_E000
    };

    logic [22:0] man_pat [4] = '{23'h000000, 23'h001000, 23'h7FFFFF, 23'h400800};

    initial begin
        repeat (3) @(negedge clk);
        check("R9", "word during reset", word_reg, 32'd0);
        rst_n = 1'b1;

        for (int m = 0; m < 2; m++) begin
            foreach (directed[i]) apply(directed[i], bit'(m));
        end
        drain();

        for (int e = 0; e < 256; e++) begin
            for (int p = 0; p < 4; p++) begin
                apply({1'(e + p), 8'(e), man_pat[p]}, bit'(e >> 1));
            end
        end
        drain();

        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            if (n % 2 == 0) r[30:23] = 8'(96 + ($urandom % 52));
            apply(r, bit'($urandom));
        end
        drain();

        // Reset in mid-run clears the registered word (R9).
        apply(32'h3F80_0000, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        pend_word.delete();
        pend_req.delete();
        @(negedge clk);
        check("R9", "word after synchronous reset", word_reg, 32'd0);
        rst_n = 1'b1;
        apply(32'hC780_0000, 1'b0);
        apply(32'h3380_0000, 1'b1);
        drain();

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog: actual %0d cycles expected completion", WATCHDOG_CYCLES);
            summary();
            $finish;
        end
    end

endmodule